// File: doc/BRIEF.md
# Serial Configuration Bitstream Source

This block is the control core of a serial configuration memory that feeds a programmable-logic device one bit per clock. A small bit array is fixed at elaboration through a parameter. A bit address counter walks through the array on the rising edges of an externally supplied data clock, and the current bit appears on a serial output that is modelled as a data bit plus an output-enable.

Two active-low control inputs decide what the block does. The rewind line, when low, takes priority: it clears the address counter and releases the data output. When rewind is high, the select line decides whether the counter advances and the output is driven. Once the last stored bit has been clocked out, the block releases its data output and pulls its active-low cascade output low. That output is wired to the select input of the next device, so that several devices form one longer stream. A power-on reset with a synchronised release puts the counter at the first bit.

Top module: `cfg_bitstream_src`

## Requirements
- R1: While the power-on reset is low, the output is not driven and the cascade output is high. After reset is released, the output stays undriven until the second rising data-clock edge. The first bit presented after that is bit 0.
- R2: While the rewind line is low, the output-enable is low in the same cycle, whatever the select level.
- R3: A rising data-clock edge with rewind low returns the position to bit 0 and sets the cascade output high.
- R4: With rewind high and select high, the output is not driven and the position holds. A later selection resumes at the same bit.
- R5: With rewind high, select low and the array not exhausted, the output is driven with CONTENT[i], where i is the current position. Index 0 is the first bit sent. Each rising edge in this state moves the position by one.
- R6: On the rising edge that consumes bit DEPTH-1, the cascade output goes low and the output stops being driven. Both conditions hold until an edge with rewind low.
- R7: Whenever the output-enable is low, the data output reads 0.
- R8: When the cascade output of one instance drives the select of a second instance that shares its clock and rewind line, the two data outputs form the first array followed by the second. In no cycle are both outputs enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dclk_i | input | 1 | External data clock; the position advances on its rising edge |
| rst_ni | input | 1 | Power-on reset, active low, asserted asynchronously |
| rewind_ni | input | 1 | Active-low rewind; clears the position and releases the output |
| sel_ni | input | 1 | Active-low select; enables advance and output drive |
| sdo_o | output | 1 | Serial data bit, 0 when not driven |
| sdo_en_o | output | 1 | Output-enable for the serial data pin |
| cascade_no | output | 1 | Active-low handoff to the next device, low once the array is exhausted |

## Verification
A single instance is driven through a table of rewind and select combinations. The table includes a deselect in the middle of the stream, to show that the position is held rather than lost. It also includes a rewind with select still low, to show that rewind wins over select, and a full run to the end of the array followed by a rewind, to show that the cascade output is sticky and then clears. A reset asserted in the middle of the stream checks the two-edge release delay. A pass through a chained pair compares every bit of the joined stream against both arrays in order, which exposes an off-by-one handoff as a missing, repeated or contended bit.

// File: rtl/cfg_src_pkg.sv
package cfg_src_pkg;

  typedef enum logic [0:0] {
    ST_ARMED = 1'b0,
    ST_SPENT = 1'b1
  } src_state_e;

  function automatic int addr_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/cfg_src_rst_sync.sv
module cfg_src_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES:0]   sync_ext;

  assign sync_ext = {sync_q, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_ext[STAGES-1:0];
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/cfg_src_ctrl.sv
module cfg_src_ctrl
  import cfg_src_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rewind_ni,
  input  logic sel_ni,
  input  logic last_i,
  output logic inc_o,
  output logic clr_o,
  output logic drive_o,
  output logic cascade_no
);

  src_state_e state_q, state_d;
  logic       armed;

  assign armed = (state_q == ST_ARMED);

  always_comb begin
    drive_o = rst_ni & rewind_ni & ~sel_ni & armed;
    inc_o   = drive_o;
    clr_o   = ~rewind_ni;
    state_d = state_q;
    if (!rewind_ni)            state_d = ST_ARMED;
    else if (inc_o && last_i)  state_d = ST_SPENT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ARMED;
    else         state_q <= state_d;
  end

  assign cascade_no = (state_q != ST_SPENT);

  // R6: the exhausted state persists until rewind
  p_spent_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SPENT && rewind_ni) |=> (state_q == ST_SPENT));

  // R3: rewind rearms the controller on the next edge
  p_rearm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rewind_ni |=> (state_q == ST_ARMED));

endmodule

// File: rtl/cfg_src_addr_ctr.sv
module cfg_src_addr_ctr #(
  parameter int DEPTH = 256,
  localparam int AW   = cfg_src_pkg::addr_width(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (clr_i)                addr_d = '0;
    else if (inc_i && !last_o) addr_d = addr_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == LAST_ADDR);

  // R5: the position never leaves the stored range
  p_addr_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= LAST_ADDR);

endmodule

// File: rtl/cfg_src_bit_rom.sv
module cfg_src_bit_rom #(
  parameter int               DEPTH   = 256,
  parameter logic [DEPTH-1:0] CONTENT = '0,
  localparam int              AW      = cfg_src_pkg::addr_width(DEPTH)
) (
  input  logic [AW-1:0] addr_i,
  output logic          bit_o
);

  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (addr_i == AW'(i)) bit_o = CONTENT[i];
    end
  end

endmodule

// File: rtl/cfg_bitstream_src.sv
module cfg_bitstream_src #(
  parameter int               DEPTH   = 256,
  parameter logic [DEPTH-1:0] CONTENT = '0,
  parameter int               SYNC_STAGES = 2
) (
  input  logic dclk_i,
  input  logic rst_ni,
  input  logic rewind_ni,
  input  logic sel_ni,
  output logic sdo_o,
  output logic sdo_en_o,
  output logic cascade_no
);

  localparam int AW = cfg_src_pkg::addr_width(DEPTH);

  logic          rst_sync_n;
  logic          inc, clr, drive, last, rom_bit;
  logic [AW-1:0] addr;

  cfg_src_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (dclk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  cfg_src_ctrl u_ctrl (
    .clk_i      (dclk_i),
    .rst_ni     (rst_sync_n),
    .rewind_ni  (rewind_ni),
    .sel_ni     (sel_ni),
    .last_i     (last),
    .inc_o      (inc),
    .clr_o      (clr),
    .drive_o    (drive),
    .cascade_no (cascade_no)
  );

  cfg_src_addr_ctr #(.DEPTH(DEPTH)) u_addr (
    .clk_i  (dclk_i),
    .rst_ni (rst_sync_n),
    .clr_i  (clr),
    .inc_i  (inc),
    .addr_o (addr),
    .last_o (last)
  );

  cfg_src_bit_rom #(.DEPTH(DEPTH), .CONTENT(CONTENT)) u_rom (
    .addr_i (addr),
    .bit_o  (rom_bit)
  );

  assign sdo_en_o = drive;
  assign sdo_o    = drive & rom_bit;

  // R1: nothing is driven while the synchronised reset is low
  p_reset_quiet_r1: assert property (@(posedge dclk_i)
    !rst_sync_n |-> (!sdo_en_o && cascade_no));

  // R2: rewind releases the output regardless of select
  p_rewind_tristate_r2: assert property (@(posedge dclk_i) disable iff (!rst_sync_n)
    !rewind_ni |-> !sdo_en_o);

  // R3: a rewind edge returns to bit 0 with the cascade output high
  p_clear_on_rewind_r3: assert property (@(posedge dclk_i) disable iff (!rst_sync_n)
    !rewind_ni |=> (addr == '0 && cascade_no));

  // R4: deselected means undriven and holding position
  p_hold_deselected_r4: assert property (@(posedge dclk_i) disable iff (!rst_sync_n)
    (rewind_ni && sel_ni) |=> $stable(addr));

  // R5: each driven edge before the last bit moves one step
  p_step_r5: assert property (@(posedge dclk_i) disable iff (!rst_sync_n)
    (sdo_en_o && !last) |=> (addr == $past(addr) + AW'(1)));

  // R6: an exhausted array never drives
  p_spent_tristate_r6: assert property (@(posedge dclk_i) disable iff (!rst_sync_n)
    !cascade_no |-> !sdo_en_o);

  // R7: undriven data reads zero
  p_zero_when_idle_r7: assert property (@(posedge dclk_i) disable iff (!rst_sync_n)
    !sdo_en_o |-> !sdo_o);

endmodule

// File: tb/tb_cfg_bitstream_src.sv
module tb_cfg_bitstream_src;

  localparam int CLK_P = 10;
  localparam int DA = 12;
  localparam int DB = 8;
  localparam logic [DA-1:0] CA = 12'hB2D;
  localparam logic [DB-1:0] CB = 8'h6E;
  localparam int NV = 24;

  // row: {rewind_n, sel_n, exp_en, exp_cascade_n, exp_idx[4:0]}
  localparam logic [8:0] VECS [0:NV-1] = '{
    {1'b1,1'b1,1'b0,1'b1,5'd0},
    {1'b1,1'b0,1'b1,1'b1,5'd0},
    {1'b1,1'b0,1'b1,1'b1,5'd1},
    {1'b1,1'b1,1'b0,1'b1,5'd0},
    {1'b1,1'b1,1'b0,1'b1,5'd0},
    {1'b1,1'b0,1'b1,1'b1,5'd2},
    {1'b0,1'b0,1'b0,1'b1,5'd0},
    {1'b0,1'b1,1'b0,1'b1,5'd0},
    {1'b1,1'b0,1'b1,1'b1,5'd0},
    {1'b1,1'b0,1'b1,1'b1,5'd1},
    {1'b1,1'b0,1'b1,1'b1,5'd2},
    {1'b1,1'b0,1'b1,1'b1,5'd3},
    {1'b1,1'b0,1'b1,1'b1,5'd4},
    {1'b1,1'b0,1'b1,1'b1,5'd5},
    {1'b1,1'b0,1'b1,1'b1,5'd6},
    {1'b1,1'b0,1'b1,1'b1,5'd7},
    {1'b1,1'b0,1'b1,1'b1,5'd8},
    {1'b1,1'b0,1'b1,1'b1,5'd9},
    {1'b1,1'b0,1'b1,1'b1,5'd10},
    {1'b1,1'b0,1'b1,1'b1,5'd11},
    {1'b1,1'b0,1'b0,1'b0,5'd0},
    {1'b1,1'b1,1'b0,1'b0,5'd0},
    {1'b0,1'b0,1'b0,1'b0,5'd0},
    {1'b1,1'b0,1'b1,1'b1,5'd0}
  };

  logic dclk, rst_n, rewind_n, sel_n;
  logic sdo_a, en_a, casc_a_n;
  logic sdo_b, en_b, casc_b_n;
  int   checks = 0;
  int   errors = 0;

  cfg_bitstream_src #(.DEPTH(DA), .CONTENT(CA)) dut (
    .dclk_i(dclk), .rst_ni(rst_n), .rewind_ni(rewind_n), .sel_ni(sel_n),
    .sdo_o(sdo_a), .sdo_en_o(en_a), .cascade_no(casc_a_n)
  );

  cfg_bitstream_src #(.DEPTH(DB), .CONTENT(CB)) dut_next (
    .dclk_i(dclk), .rst_ni(rst_n), .rewind_ni(rewind_n), .sel_ni(casc_a_n),
    .sdo_o(sdo_b), .sdo_en_o(en_b), .cascade_no(casc_b_n)
  );

  initial begin
    dclk = 1'b0;
    forever #(CLK_P/2) dclk = ~dclk;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rewind_n = 1'b1; sel_n = 1'b0;
    repeat (3) @(negedge dclk);
    #1;
    check("R1 en in reset", {31'b0, en_a}, 0);
    check("R1 cascade in reset", {31'b0, casc_a_n}, 1);
    check("R7 data in reset", {31'b0, sdo_a}, 0);
    @(negedge dclk);
    sel_n = 1'b1; rst_n = 1'b1;
    repeat (2) @(negedge dclk);

    // table walk on the first instance
    for (int v = 0; v < NV; v++) begin
      logic [8:0] row;
      string tag;
      row = VECS[v];
      rewind_n = row[8]; sel_n = row[7];
      #1;
      if (!row[8])      tag = "R2/R3 rewind";
      else if (row[7])  tag = "R4 deselected";
      else if (!row[5]) tag = "R6 exhausted";
      else              tag = "R5 stream";
      check({tag, " en"}, {31'b0, en_a}, {31'b0, row[6]});
      check({tag, " data"}, {31'b0, sdo_a}, row[6] ? {31'b0, CA[row[4:0]]} : 32'd0);
      check({tag, " cascade"}, {31'b0, casc_a_n}, {31'b0, row[5]});
      check("R8 overlap", {31'b0, en_a & en_b}, 0);
      @(negedge dclk);
    end

    // reset in mid-stream, two-edge release
    rst_n = 1'b0; rewind_n = 1'b1; sel_n = 1'b0;
    #1;
    check("R1 mid-stream reset en", {31'b0, en_a}, 0);
    check("R1 mid-stream reset cascade", {31'b0, casc_a_n}, 1);
    @(negedge dclk);
    rst_n = 1'b1;
    #1;
    check("R1 release edge0 en", {31'b0, en_a}, 0);
    @(negedge dclk); #1;
    check("R1 release edge1 en", {31'b0, en_a}, 0);
    @(negedge dclk); #1;
    check("R1 release edge2 en", {31'b0, en_a}, 1);
    check("R1 first bit", {31'b0, sdo_a}, {31'b0, CA[0]});

    // chained stream
    @(negedge dclk);
    rewind_n = 1'b0; sel_n = 1'b0;
    #1;
    check("R2 both released", {30'b0, en_a, en_b}, 0);
    @(negedge dclk);
    rewind_n = 1'b1;
    for (int k = 0; k < DA + DB; k++) begin
      logic expb;
      expb = (k < DA) ? CA[k] : CB[k - DA];
      #1;
      check("R8 one driver", {30'b0, en_a, en_b}, (k < DA) ? 32'd2 : 32'd1);
      check("R8 joined bit", {31'b0, (sdo_a | sdo_b)}, {31'b0, expb});
      @(negedge dclk);
    end
    #1;
    check("R6 both cascades low", {30'b0, casc_a_n, casc_b_n}, 0);
    check("R6 both released", {30'b0, en_a, en_b}, 0);
    check("R7 both data zero", {30'b0, sdo_a, sdo_b}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule